// File: doc/BRIEF.md
# Sprite Pixel Coverage and Fetch Unit

This unit serves one freely placed 16x16 sprite of a tile-based video generator. A display chip instantiates one copy per sprite slot, up to 128 of them, so no limit exists on the number of sprites sharing a scanline. Each copy keeps a private register copy of its sprite's attribute entry: horizontal and vertical position, tile number, palette number and two mirror bits. Every pixel coordinate streamed past it is tested against the sprite's box. For a covered pixel the unit forms the address of the pixel's colour index in the shared 1024-tile pattern memory, reads that memory, and reports whether the sprite shows an opaque pixel there.

Position fields are biased by 15. A stored value of 0 places the sprite 15 pixels beyond the top or left edge, so only its last row or column is on screen. Large values push it past the right or bottom edge, so the sprite can leave the screen on all four sides. The attribute copy changes only while vertical blanking is active. A load that arrives during active display is parked and takes effect once blanking begins, so a frame is never drawn with a half-updated sprite. Arbitration between sprites is left to the compositor that consumes the outputs.

Top module: `spr_pixel_unit`

## Requirements
- R1: While and after synchronous reset with no pixel strobe, `px_vld_o`, `hit_o`, `cidx_o` and `pal_o` are all 0, and the cached attribute entry is all zeros.
- R2: With x field X and y field Y, the sprite covers screen pixel (sx, sy) exactly when X-15 <= sx <= X and Y-15 <= sy <= Y, using signed arithmetic. A field of 0 covers only screen coordinate 0, and a field above the screen size places the sprite partly or wholly past the right or bottom edge.
- R3: For a covered pixel with column c = sx-(X-15) and row r = sy-(Y-15), before mirroring, the pattern-memory address is {tile[9:0], r[3:0], c[3:0]}, 18 bits, with the tile number in the upper bits.
- R4: When the horizontal mirror bit is set, the column used in the address is 15-c.
- R5: When the vertical mirror bit is set, the row used in the address is 15-r.
- R6: A colour index of 0 read from pattern memory is transparent. It gives `hit_o`=0 and `cidx_o`=0, even inside the box.
- R7: When `hit_o`=1, `cidx_o` is the nonzero index read and `pal_o` is the entry's palette number. When `hit_o`=0, both are 0.
- R8: The attribute entry on `ld_attr_i` is 33 bits: [8:0] x field, [17:9] y field, [27:18] tile, [30:28] palette, [31] horizontal mirror, [32] vertical mirror. A load taken with `vblank_i`=1 is used for every pixel strobed from the following cycle on.
- R9: A load taken with `vblank_i`=0 does not change any pixel result until `vblank_i` is high. At the first cycle of blanking the parked entry becomes active. The active entry never changes while `vblank_i` is low.
- R10: Each strobed pixel produces exactly one result with `px_vld_o`=1, three clock edges after the strobe edge. Cycles without a strobe give `px_vld_o`=0 and `hit_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| px_en_i | input | 1 | Pixel strobe; coordinates valid |
| px_x_i | input | 9 | Screen column of the pixel |
| px_y_i | input | 9 | Screen row of the pixel |
| vblank_i | input | 1 | Vertical blanking interval active |
| ld_en_i | input | 1 | Attribute entry load strobe |
| ld_attr_i | input | 33 | Attribute entry to load |
| tm_addr_o | output | 18 | Pattern memory read address |
| tm_rd_en_o | output | 1 | Pattern memory read enable |
| tm_data_i | input | 3 | Colour index returned one cycle after the address |
| px_vld_o | output | 1 | Result valid |
| hit_o | output | 1 | Sprite shows an opaque pixel here |
| cidx_o | output | 3 | Colour index of the hit pixel |
| pal_o | output | 3 | Palette number of the hit pixel |

## Verification
The hardest case is a load parked during active display. To reach it, the stimulus loads one entry during blanking, leaves blanking, and loads a second entry placed elsewhere. It then streams pixels over both boxes and expects results from the first entry only. After that it raises blanking and repeats the same pixels against the second entry. The edge cases come from field values 0 and 270, which put the box across the top-left corner and across the right edge, with mirroring enabled.

// File: rtl/spr_pkg.sv
package spr_pkg;
  parameter int XW  = 9;   // screen / field x width
  parameter int YW  = 9;   // screen / field y width
  parameter int TW  = 10;  // tile number width
  parameter int PW  = 3;   // palette number width
  parameter int CW  = 3;   // colour index width
  parameter int SZL = 4;   // log2 of sprite edge length

  localparam int AW = TW + 2 * SZL;  // pattern memory address width

  typedef struct packed {
    logic          mir_v;
    logic          mir_h;
    logic [PW-1:0] pal;
    logic [TW-1:0] tile;
    logic [YW-1:0] ypos;
    logic [XW-1:0] xpos;
  } spr_attr_t;

  localparam int ATTR_W = $bits(spr_attr_t);
endpackage

// File: rtl/spr_attr_cache.sv
module spr_attr_cache
  import spr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      vblank_i,
  input  logic      ld_en_i,
  input  spr_attr_t ld_attr_i,
  output spr_attr_t act_o
);
  spr_attr_t park_q;
  logic      park_vld_q;
  spr_attr_t act_q;

  // Parking register holds loads seen during active display.
  always_ff @(posedge clk) begin
    if (rst) begin
      park_q     <= '0;
      park_vld_q <= 1'b0;
    end else if (ld_en_i && !vblank_i) begin
      park_q     <= ld_attr_i;
      park_vld_q <= 1'b1;
    end else if (vblank_i) begin
      park_vld_q <= 1'b0;
    end
  end

  // Active copy only moves while blanking; a direct load wins over a parked one.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
    end else if (vblank_i) begin
      if (ld_en_i)         act_q <= ld_attr_i;
      else if (park_vld_q) act_q <= park_q;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/spr_axis_ofs.sv
module spr_axis_ofs #(
  parameter int W   = 9,
  parameter int SZL = 4
) (
  input  logic [W-1:0]   scr_i,
  input  logic [W-1:0]   fld_i,
  input  logic           mir_i,
  output logic           in_o,
  output logic [SZL-1:0] ofs_o
);
  localparam int RW = W + 2;
  localparam logic [RW-1:0] BIAS = RW'((1 << SZL) - 1);

  logic [RW-1:0] rel;

  always_comb begin
    rel   = {2'b00, scr_i} + BIAS - {2'b00, fld_i};
    in_o  = (rel[RW-1:SZL] == '0);
    ofs_o = mir_i ? ~rel[SZL-1:0] : rel[SZL-1:0];
  end
endmodule

// File: rtl/spr_locate.sv
module spr_locate
  import spr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          px_en_i,
  input  logic [XW-1:0] px_x_i,
  input  logic [YW-1:0] px_y_i,
  input  spr_attr_t     attr_i,
  output logic [AW-1:0] tm_addr_o,
  output logic          tm_rd_en_o,
  output logic          s1_vld_o,
  output logic          s1_in_o,
  output logic [PW-1:0] s1_pal_o
);
  localparam int NAX = 2;

  logic [NAX-1:0] ax_in;
  logic [SZL-1:0] ax_ofs [NAX];

  genvar g;
  generate
    for (g = 0; g < NAX; g++) begin : g_axis
      if (g == 0) begin : g_col
        spr_axis_ofs #(.W(XW), .SZL(SZL)) i_ax (
          .scr_i(px_x_i), .fld_i(attr_i.xpos), .mir_i(attr_i.mir_h),
          .in_o(ax_in[g]), .ofs_o(ax_ofs[g]));
      end else begin : g_row
        spr_axis_ofs #(.W(YW), .SZL(SZL)) i_ax (
          .scr_i(px_y_i), .fld_i(attr_i.ypos), .mir_i(attr_i.mir_v),
          .in_o(ax_in[g]), .ofs_o(ax_ofs[g]));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      tm_addr_o  <= '0;
      tm_rd_en_o <= 1'b0;
      s1_vld_o   <= 1'b0;
      s1_in_o    <= 1'b0;
      s1_pal_o   <= '0;
    end else begin
      tm_addr_o  <= {attr_i.tile, ax_ofs[1], ax_ofs[0]};
      tm_rd_en_o <= px_en_i && (&ax_in);
      s1_vld_o   <= px_en_i;
      s1_in_o    <= &ax_in;
      s1_pal_o   <= attr_i.pal;
    end
  end
endmodule

// File: rtl/spr_pix_out.sv
module spr_pix_out
  import spr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          s1_vld_i,
  input  logic          s1_in_i,
  input  logic [PW-1:0] s1_pal_i,
  input  logic [CW-1:0] tm_data_i,
  output logic          px_vld_o,
  output logic          hit_o,
  output logic [CW-1:0] cidx_o,
  output logic [PW-1:0] pal_o
);
  logic          s2_vld_q;
  logic          s2_in_q;
  logic [PW-1:0] s2_pal_q;
  logic          opaque;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld_q <= 1'b0;
      s2_in_q  <= 1'b0;
      s2_pal_q <= '0;
    end else begin
      s2_vld_q <= s1_vld_i;
      s2_in_q  <= s1_vld_i && s1_in_i;
      s2_pal_q <= s1_pal_i;
    end
  end

  assign opaque = s2_in_q && (tm_data_i != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      px_vld_o <= 1'b0;
      hit_o    <= 1'b0;
      cidx_o   <= '0;
      pal_o    <= '0;
    end else begin
      px_vld_o <= s2_vld_q;
      hit_o    <= opaque;
      cidx_o   <= opaque ? tm_data_i : '0;
      pal_o    <= opaque ? s2_pal_q : '0;
    end
  end
endmodule

// File: rtl/spr_pixel_unit.sv
module spr_pixel_unit
  import spr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              px_en_i,
  input  logic [XW-1:0]     px_x_i,
  input  logic [YW-1:0]     px_y_i,
  input  logic              vblank_i,
  input  logic              ld_en_i,
  input  logic [ATTR_W-1:0] ld_attr_i,
  output logic [AW-1:0]     tm_addr_o,
  output logic              tm_rd_en_o,
  input  logic [CW-1:0]     tm_data_i,
  output logic              px_vld_o,
  output logic              hit_o,
  output logic [CW-1:0]     cidx_o,
  output logic [PW-1:0]     pal_o
);
  spr_attr_t     act_attr;
  logic          s1_vld;
  logic          s1_in;
  logic [PW-1:0] s1_pal;

  spr_attr_cache i_cache (
    .clk(clk), .rst(rst), .vblank_i(vblank_i), .ld_en_i(ld_en_i),
    .ld_attr_i(spr_attr_t'(ld_attr_i)), .act_o(act_attr));

  spr_locate i_loc (
    .clk(clk), .rst(rst), .px_en_i(px_en_i), .px_x_i(px_x_i), .px_y_i(px_y_i),
    .attr_i(act_attr), .tm_addr_o(tm_addr_o), .tm_rd_en_o(tm_rd_en_o),
    .s1_vld_o(s1_vld), .s1_in_o(s1_in), .s1_pal_o(s1_pal));

  spr_pix_out i_out (
    .clk(clk), .rst(rst), .s1_vld_i(s1_vld), .s1_in_i(s1_in), .s1_pal_i(s1_pal),
    .tm_data_i(tm_data_i), .px_vld_o(px_vld_o), .hit_o(hit_o),
    .cidx_o(cidx_o), .pal_o(pal_o));
endmodule

module spr_pixel_unit_chk
  import spr_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          px_en_i,
  input logic          vblank_i,
  input logic          px_vld_o,
  input logic          hit_o,
  input logic [CW-1:0] cidx_o,
  input logic [PW-1:0] pal_o,
  input spr_attr_t     act_attr
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (px_vld_o == $past(px_en_i, 3)));

  // R10
  hit_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> px_vld_o);

  // R6
  opaque_chk: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (cidx_o != '0));

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (cidx_o == '0 && pal_o == '0));

  // R9
  attr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !vblank_i |=> $stable(act_attr));
endmodule

bind spr_pixel_unit spr_pixel_unit_chk i_chk (
  .clk(clk), .rst(rst), .px_en_i(px_en_i), .vblank_i(vblank_i),
  .px_vld_o(px_vld_o), .hit_o(hit_o), .cidx_o(cidx_o), .pal_o(pal_o),
  .act_attr(act_attr));

// File: tb/test_spr_pixel_unit.sv
module test_spr_pixel_unit;
  import spr_pkg::*;

  localparam int CLK_P = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              px_en_i = 1'b0;
  logic [XW-1:0]     px_x_i = '0;
  logic [YW-1:0]     px_y_i = '0;
  logic              vblank_i = 1'b0;
  logic              ld_en_i = 1'b0;
  logic [ATTR_W-1:0] ld_attr_i = '0;
  logic [AW-1:0]     tm_addr_o;
  logic              tm_rd_en_o;
  logic [CW-1:0]     tm_data_i;
  logic              px_vld_o, hit_o;
  logic [CW-1:0]     cidx_o;
  logic [PW-1:0]     pal_o;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  typedef struct packed { logic hit; logic [CW-1:0] cidx; logic [PW-1:0] pal; } res_t;
  res_t      exp_q[$];
  string     tag_q[$];
  spr_attr_t model;

  always #(CLK_P/2) clk = ~clk;

  spr_pixel_unit i_spr_pixel_unit (.*);

  function automatic logic [CW-1:0] tile_fn(logic [AW-1:0] a);
    return a[2:0] ^ a[6:4] ^ a[10:8] ^ a[13:11] ^ a[17:15];
  endfunction

  // Pattern memory: one-cycle registered read.
  always_ff @(posedge clk) tm_data_i <= tile_fn(tm_addr_o);

  function automatic res_t expect_px(int sx, int sy, spr_attr_t a);
    res_t r;
    int c, rw;
    logic [AW-1:0] adr;
    logic [CW-1:0] v;
    c  = sx - (int'(a.xpos) - 15);
    rw = sy - (int'(a.ypos) - 15);
    r  = '0;
    if (c >= 0 && c <= 15 && rw >= 0 && rw <= 15) begin
      if (a.mir_h) c = 15 - c;
      if (a.mir_v) rw = 15 - rw;
      adr = {a.tile, 4'(rw), 4'(c)};
      v = tile_fn(adr);
      if (v != 0) begin r.hit = 1'b1; r.cidx = v; r.pal = a.pal; end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_px(int sx, int sy, string tag);
    px_en_i = 1'b1;
    px_x_i  = XW'(sx);
    px_y_i  = YW'(sy);
    exp_q.push_back(expect_px(sx, sy, model));
    tag_q.push_back(tag);
    @(negedge clk);
    px_en_i = 1'b0;
  endtask

  task automatic load(spr_attr_t a);
    ld_en_i = 1'b1;
    ld_attr_i = a;
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  task automatic drain();
    repeat (5) @(negedge clk);
  endtask

  // Monitor: compare each valid result with the oldest expected item.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (px_vld_o) begin
        if (exp_q.size() == 0) begin
          check("R10 unexpected result", 32'(px_vld_o), 32'd0);
        end else begin
          res_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, 32'({hit_o, cidx_o, pal_o}), 32'(e));
        end
      end else if (hit_o) begin
        check("R10 hit without valid", 32'(hit_o), 32'd0);
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    spr_attr_t a, b;
    model = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 vld", 32'(px_vld_o), 0);
    check("R1 outs", 32'({hit_o, cidx_o, pal_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    // R1 zero entry: field 0 covers only pixel (0,0)
    drive_px(0, 0, "R1 R2 reset entry at origin");
    drive_px(1, 0, "R1 R2 reset entry right of origin");
    drain();

    // R8 load during blanking, then R2 R3 box scan
    vblank_i = 1'b1;
    a = '{mir_v:1'b0, mir_h:1'b0, pal:3'd5, tile:10'd37, ypos:9'd60, xpos:9'd100};
    load(a);
    model = a;
    drive_px(85, 45, "R8 first pixel after vblank load");
    vblank_i = 1'b0;
    for (int y = 43; y <= 62; y += 3)
      for (int x = 83; x <= 102; x++)
        drive_px(x, y, "R2 R3 R6 R7 box scan");
    drain();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R10 idle no valid", 32'(px_vld_o), 0);
    end

    // R4 R5 mirroring
    for (int m = 1; m < 4; m++) begin
      vblank_i = 1'b1;
      a.mir_h = m[0];
      a.mir_v = m[1];
      a.tile  = 10'(200 + m);
      load(a);
      model = a;
      vblank_i = 1'b0;
      for (int y = 45; y <= 60; y += 5)
        for (int x = 85; x <= 100; x++)
          drive_px(x, y, m == 1 ? "R4 horizontal mirror" :
                         m == 2 ? "R5 vertical mirror" : "R4 R5 both mirrors");
      drain();
    end

    // R2 corner and right edge placement
    vblank_i = 1'b1;
    a = '{mir_v:1'b1, mir_h:1'b1, pal:3'd2, tile:10'd1023, ypos:9'd3, xpos:9'd0};
    load(a);
    model = a;
    vblank_i = 1'b0;
    for (int y = 0; y <= 4; y++)
      for (int x = 0; x <= 2; x++)
        drive_px(x, y, "R2 top-left overhang");
    drain();
    vblank_i = 1'b1;
    a = '{mir_v:1'b0, mir_h:1'b1, pal:3'd7, tile:10'd512, ypos:9'd230, xpos:9'd270};
    load(a);
    model = a;
    vblank_i = 1'b0;
    for (int y = 214; y <= 231; y += 4)
      for (int x = 250; x <= 272; x++)
        drive_px(x, y, "R2 bottom-right overhang");
    drain();

    // R9 parked load: no effect until blanking
    vblank_i = 1'b1;
    a = '{mir_v:1'b0, mir_h:1'b0, pal:3'd1, tile:10'd9, ypos:9'd40, xpos:9'd40};
    load(a);
    model = a;
    vblank_i = 1'b0;
    b = '{mir_v:1'b1, mir_h:1'b0, pal:3'd6, tile:10'd77, ypos:9'd150, xpos:9'd150};
    load(b);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      drive_px(25 + k, 30, "R9 parked load ignored (old box)");
      drive_px(135 + k, 140, "R9 parked load ignored (new box)");
    end
    drain();
    vblank_i = 1'b1;
    @(negedge clk);
    model = b;
    for (int k = 0; k < 16; k++) begin
      drive_px(25 + k, 30, "R9 parked load applied (old box)");
      drive_px(135 + k, 140, "R9 parked load applied (new box)");
    end
    vblank_i = 1'b0;
    drain();

    check("R10 all results returned", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule